// File: doc/BRIEF.md
# Chained descriptor DMA engine

This block is the internal DMA engine of an SD/MMC host controller. Software builds a list of four-word descriptors in memory, writes the list's start address, and the engine walks the list on its own. For each descriptor it moves the described buffer between memory and the controller's data FIFO. Each descriptor has an ownership bit that hands the descriptor to the engine. When a buffer is finished, the engine clears that bit in memory to give the descriptor back.

The memory side is a 32-bit request/response port with at most one transaction in flight. The FIFO side has two valid/ready word streams: an outbound stream for transmit (memory to card) and an inbound stream for receive (card to memory). The `dir_rx_i` input sets the direction when a walk starts. Completion and error events collect in a sticky status register. An interrupt enable mask gates those events onto a single interrupt line.

Software programs four registers through a write-only port selected by `csr_sel`: 0 control, 1 list base, 2 status clear, 3 interrupt enable.

Top module: `desc_dma_engine`

## Requirements
- R1: A descriptor occupies four consecutive 32-bit words at byte offsets 0, 4, 8 and 12: config, buffer size in bytes, buffer address, next-descriptor address. They are read in that order, and a memory request holds its address and direction until its response arrives.
- R2: If config bit 31 (owned by engine) reads as 0, the engine stops without touching the buffer. It sets status bit 4 (descriptor invalid) and bit 9 (abnormal summary).
- R3: In transmit mode the engine reads ceil(size/4) words from consecutive buffer addresses and presents them on the tx stream in address order. A size of 0 moves no word. Presented data holds until it is accepted.
- R4: In receive mode each word accepted on the rx stream is written to the next buffer address, ceil(size/4) words per descriptor.
- R5: After the buffer is done, the config word is written back with bit 31 cleared. Bit 30 is set if the card error input pulsed during that descriptor. Bits 29:0 are unchanged.
- R6: After write-back the engine stops if config bit 2 (last) is set. Otherwise the next descriptor is at the next-address word if bit 4 (chained) is set. If bit 4 is clear, it is at the list base when bit 5 (end of ring) is set, and at the current address + 16 when bit 5 is clear.
- R7: Write-back of a descriptor whose config bit 1 (interrupt disable) is clear sets status bit 0 (transmit) or bit 1 (receive). Status bit 8 reads as the OR of bits 0 and 1.
- R8: An error response on the memory port halts the engine and sets status bits 2 (bus error) and 9.
- R9: The per-descriptor length is clamped to 8 KiB, or to 64 KiB when parameter LARGE_BUF is 1.
- R10: Clearing control bit 7 (run) while the engine is busy halts it and sets status bits 10 (host abort) and 9.
- R11: A card error pulse while busy sets status bit 5 and bit 9. The engine keeps running.
- R12: Writing 1 to a status bit clears it. `irq_o` is the OR of status AND the interrupt enable mask. Writing control with bit 0 set clears status, mask, base and control.
- R13: Writing the list base while run is set starts a walk at that address. With run clear, the write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 control, 1 base, 2 status clear, 3 interrupt enable |
| csr_wdata | input | 32 | Register write data |
| dir_rx_i | input | 1 | Walk direction, 1 = receive, sampled at start |
| card_err_i | input | 1 | Card error pulse from the card-side logic |
| status_o | output | 32 | Status register |
| irq_o | output | 1 | DMA interrupt |
| busy_o | output | 1 | Engine is walking a list |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Response for the current request |
| mem_err_i | input | 1 | Response carries an error |
| mem_rdata_i | input | 32 | Read data with the response |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_data_o | output | 32 | Transmit word |
| tx_ready_i | input | 1 | FIFO accepts transmit word |
| rx_valid_i | input | 1 | Receive word valid |
| rx_data_i | input | 32 | Receive word |
| rx_ready_o | output | 1 | Engine accepts receive word |

## Verification
The assertions check handshake stability on every cycle: a pending memory request and an unaccepted tx word must both hold steady. They also check that each halting event (bus error, run cleared) stops the engine and sets its status bits on the next cycle, and that a card error pulse sets its flag. Walk order can only be shown by the bench's scenarios, which compare memory and stream traffic against descriptor lists built in the bench. Those scenarios cover chained, sequential and ring-wrapped lists, ownership write-back, interrupt suppression on all but the last descriptor, and the length clamp.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_RD, S_PUSH, S_PULL, S_WR, S_WBACK
   } walk_st_e;

   // descriptor config word bit positions
   localparam int CF_NOINT = 1;
   localparam int CF_LAST  = 2;
   localparam int CF_CHAIN = 4;
   localparam int CF_RING  = 5;
   localparam int CF_CERR  = 30;
   localparam int CF_OWN   = 31;

   // status bit positions
   localparam int ST_TXD   = 0;
   localparam int ST_RXD   = 1;
   localparam int ST_BUS   = 2;
   localparam int ST_INV   = 4;
   localparam int ST_CERR  = 5;
   localparam int ST_NSUM  = 8;
   localparam int ST_ASUM  = 9;
   localparam int ST_ABORT = 10;
   localparam int ST_W     = 11;

   // control bit positions
   localparam int CT_SRST = 0;
   localparam int CT_RUN  = 7;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_BASE = 2'd1;
   localparam logic [1:0] SEL_STAT = 2'd2;
   localparam logic [1:0] SEL_IEN  = 2'd3;

   typedef struct packed {
      logic tx_done;
      logic rx_done;
      logic bus_err;
      logic desc_inv;
      logic abort;
   } dma_ev_t;
endpackage

// File: rtl/desc_dma_regs.sv
module desc_dma_regs
   import desc_dma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [1:0]  csr_sel,
   input  logic [31:0] csr_wdata,
   input  dma_ev_t     ev,
   input  logic        card_err,
   input  logic        busy,
   output logic        run_o,
   output logic        srst_o,
   output logic        start_o,
   output logic [31:0] base_o,
   output logic [31:0] status_o,
   output logic        irq_o
);
   localparam logic [ST_W-1:0] STICKY_MASK =
      ST_W'((1 << ST_TXD) | (1 << ST_RXD) | (1 << ST_BUS) |
            (1 << ST_INV) | (1 << ST_CERR) | (1 << ST_ABORT));

   logic [ST_W-1:0] sticky_q, ien_q, stat_w, set_w, nxt_w;
   logic            run_q, srst_q, start_q;
   logic [31:0]     base_q;

   always_comb begin
      set_w           = '0;
      set_w[ST_TXD]   = ev.tx_done;
      set_w[ST_RXD]   = ev.rx_done;
      set_w[ST_BUS]   = ev.bus_err;
      set_w[ST_INV]   = ev.desc_inv;
      set_w[ST_CERR]  = card_err && busy;
      set_w[ST_ABORT] = ev.abort;
      nxt_w = sticky_q;
      if (csr_we && csr_sel == SEL_STAT) nxt_w = nxt_w & ~csr_wdata[ST_W-1:0];
      nxt_w = (nxt_w | set_w) & STICKY_MASK;
   end

   always_comb begin
      stat_w           = sticky_q;
      stat_w[ST_NSUM]  = sticky_q[ST_TXD] | sticky_q[ST_RXD];
      stat_w[ST_ASUM]  = sticky_q[ST_BUS] | sticky_q[ST_INV] |
                         sticky_q[ST_CERR] | sticky_q[ST_ABORT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         ien_q    <= '0;
         run_q    <= 1'b0;
         srst_q   <= 1'b0;
         start_q  <= 1'b0;
         base_q   <= '0;
      end else if (srst_q) begin
         sticky_q <= '0;
         ien_q    <= '0;
         run_q    <= 1'b0;
         srst_q   <= 1'b0;
         start_q  <= 1'b0;
         base_q   <= '0;
      end else begin
         sticky_q <= nxt_w;
         srst_q   <= csr_we && csr_sel == SEL_CTRL && csr_wdata[CT_SRST];
         start_q  <= csr_we && csr_sel == SEL_BASE && run_q;
         if (csr_we && csr_sel == SEL_CTRL)
            run_q <= csr_wdata[CT_RUN] && !csr_wdata[CT_SRST];
         if (csr_we && csr_sel == SEL_BASE) base_q <= csr_wdata;
         if (csr_we && csr_sel == SEL_IEN)  ien_q  <= csr_wdata[ST_W-1:0];
      end
   end

   assign run_o    = run_q;
   assign srst_o   = srst_q;
   assign start_o  = start_q;
   assign base_o   = base_q;
   assign status_o = {{(32-ST_W){1'b0}}, stat_w};
   assign irq_o    = |(stat_w & ien_q);
endmodule

// File: rtl/desc_dma_walker.sv
module desc_dma_walker
   import desc_dma_pkg::*;
#(
   parameter int LOG_MAX = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        srst,
   input  logic        run,
   input  logic        start,
   input  logic        dir_rx,
   input  logic [31:0] base,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_rsp,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   output logic        tx_valid,
   output logic [31:0] tx_data,
   input  logic        tx_ready,
   input  logic        rx_valid,
   input  logic [31:0] rx_data,
   output logic        rx_ready,
   input  logic        card_err,
   output logic        busy,
   output dma_ev_t     ev
);
   localparam int LEN_W  = LOG_MAX + 1;
   localparam int WCNT_W = LEN_W - 2;

   walk_st_e          st;
   logic [1:0]        idx;
   logic [31:0]       dsc, cfg, ptr, nxt, dat;
   logic [WCNT_W-1:0] left;
   logic              dir, ces;

   logic              rsp_ok, hit_err, stop_run, done;
   logic [LEN_W-1:0]  eff_len, rnd_len;
   logic [WCNT_W-1:0] words;

   // clamp the requested byte count and round it up to whole words
   always_comb begin
      eff_len = (|mem_rdata[31:LOG_MAX]) ? LEN_W'(1 << LOG_MAX)
                                         : {1'b0, mem_rdata[LOG_MAX-1:0]};
      rnd_len = eff_len + LEN_W'(3);
      words   = rnd_len[LEN_W-1:2];
   end

   always_comb begin
      mem_req  = st inside {S_FETCH, S_RD, S_WR, S_WBACK};
      mem_we   = st inside {S_WR, S_WBACK};
      unique case (st)
         S_FETCH: mem_addr = dsc + {28'd0, idx, 2'b00};
         S_RD,
         S_WR:    mem_addr = ptr;
         default: mem_addr = dsc;
      endcase
      mem_wdata = (st == S_WBACK) ? {1'b0, ces, cfg[CF_CERR-1:0]} : dat;
      tx_valid  = st == S_PUSH;
      tx_data   = dat;
      rx_ready  = st == S_PULL;
      busy      = st != S_IDLE;
   end

   always_comb begin
      stop_run    = busy && !run;
      rsp_ok      = mem_req && mem_rsp && !mem_err;
      hit_err     = mem_req && mem_rsp && mem_err;
      done        = st == S_WBACK && rsp_ok && !cfg[CF_NOINT] && !stop_run && !srst;
      ev.abort    = stop_run && !srst;
      ev.bus_err  = hit_err && !stop_run && !srst;
      ev.desc_inv = st == S_FETCH && idx == 2'd0 && rsp_ok &&
                    !mem_rdata[CF_OWN] && !stop_run && !srst;
      ev.tx_done  = done && !dir;
      ev.rx_done  = done && dir;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; idx <= '0; dsc <= '0; cfg <= '0; ptr <= '0;
         nxt <= '0; dat <= '0; left <= '0; dir <= 1'b0; ces <= 1'b0;
      end else if (srst || stop_run || hit_err) begin
         st <= S_IDLE;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               dsc <= base; idx <= '0; dir <= dir_rx; ces <= 1'b0; st <= S_FETCH;
            end
            S_FETCH: if (mem_rsp) begin
               idx <= idx + 2'd1;
               unique case (idx)
                  2'd0: begin
                     cfg <= mem_rdata;
                     if (!mem_rdata[CF_OWN]) st <= S_IDLE;
                  end
                  2'd1: left <= words;
                  2'd2: ptr  <= mem_rdata;
                  default: begin
                     nxt <= mem_rdata;
                     st  <= (left == '0) ? S_WBACK : (dir ? S_PULL : S_RD);
                  end
               endcase
            end
            S_RD: if (mem_rsp) begin
               dat <= mem_rdata; st <= S_PUSH;
            end
            S_PUSH: if (tx_ready) begin
               ptr  <= ptr + 32'd4;
               left <= left - 1'b1;
               st   <= (left == WCNT_W'(1)) ? S_WBACK : S_RD;
            end
            S_PULL: if (rx_valid) begin
               dat <= rx_data; st <= S_WR;
            end
            S_WR: if (mem_rsp) begin
               ptr  <= ptr + 32'd4;
               left <= left - 1'b1;
               st   <= (left == WCNT_W'(1)) ? S_WBACK : S_PULL;
            end
            default: if (mem_rsp) begin
               idx <= '0;
               ces <= 1'b0;
               if (cfg[CF_LAST])       st <= S_IDLE;
               else begin
                  st <= S_FETCH;
                  if (cfg[CF_CHAIN])     dsc <= nxt;
                  else if (cfg[CF_RING]) dsc <= base;
                  else                   dsc <= dsc + 32'd16;
               end
            end
         endcase
         if (card_err && busy && !(st == S_WBACK && mem_rsp)) ces <= 1'b1;
      end
   end
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
   import desc_dma_pkg::*;
#(
   parameter int LARGE_BUF = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [1:0]  csr_sel,
   input  logic [31:0] csr_wdata,
   input  logic        dir_rx_i,
   input  logic        card_err_i,
   output logic [31:0] status_o,
   output logic        irq_o,
   output logic        busy_o,
   output logic        mem_req_o,
   output logic        mem_we_o,
   output logic [31:0] mem_addr_o,
   output logic [31:0] mem_wdata_o,
   input  logic        mem_rsp_i,
   input  logic        mem_err_i,
   input  logic [31:0] mem_rdata_i,
   output logic        tx_valid_o,
   output logic [31:0] tx_data_o,
   input  logic        tx_ready_i,
   input  logic        rx_valid_i,
   input  logic [31:0] rx_data_i,
   output logic        rx_ready_o
);
   localparam int LOG_MAX = (LARGE_BUF != 0) ? 16 : 13;

   generate
      if (LARGE_BUF != 0 && LARGE_BUF != 1) begin : g_bad_len
         $error("LARGE_BUF must be 0 (8 KiB) or 1 (64 KiB)");
      end
   endgenerate

   logic        run_w, srst_w, start_w;
   logic [31:0] base_w;
   dma_ev_t     ev_w;

   desc_dma_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .csr_we   (csr_we),
      .csr_sel  (csr_sel),
      .csr_wdata(csr_wdata),
      .ev       (ev_w),
      .card_err (card_err_i),
      .busy     (busy_o),
      .run_o    (run_w),
      .srst_o   (srst_w),
      .start_o  (start_w),
      .base_o   (base_w),
      .status_o (status_o),
      .irq_o    (irq_o)
   );

   desc_dma_walker #(.LOG_MAX(LOG_MAX)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst_w),
      .run      (run_w),
      .start    (start_w),
      .dir_rx   (dir_rx_i),
      .base     (base_w),
      .mem_req  (mem_req_o),
      .mem_we   (mem_we_o),
      .mem_addr (mem_addr_o),
      .mem_wdata(mem_wdata_o),
      .mem_rsp  (mem_rsp_i),
      .mem_err  (mem_err_i),
      .mem_rdata(mem_rdata_i),
      .tx_valid (tx_valid_o),
      .tx_data  (tx_data_o),
      .tx_ready (tx_ready_i),
      .rx_valid (rx_valid_i),
      .rx_data  (rx_data_i),
      .rx_ready (rx_ready_o),
      .card_err (card_err_i),
      .busy     (busy_o),
      .ev       (ev_w)
   );
endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        run,
   input logic        srst,
   input logic        busy,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic        mem_rsp,
   input logic        mem_err,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic [31:0] tx_data,
   input logic        card_err,
   input logic        st_bus,
   input logic        st_cerr,
   input logic        st_asum,
   input logic        st_abort
);
   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rsp && run) |=>
         ((mem_req && $stable(mem_addr) && $stable(mem_we)) || !run));

   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && run) |=>
         ((tx_valid && $stable(tx_data)) || !run));

   // R8
   bus_halt_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (mem_req && mem_rsp && mem_err && run) |=> (!busy && st_bus && st_asum));

   // R10
   abort_halt_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (busy && !run) |=> (!busy && st_abort && st_asum));

   // R11
   card_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (card_err && busy) |=> (st_cerr && st_asum));
endmodule

bind desc_dma_engine desc_dma_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run_w),
   .srst    (srst_w),
   .busy    (busy_o),
   .mem_req (mem_req_o),
   .mem_we  (mem_we_o),
   .mem_addr(mem_addr_o),
   .mem_rsp (mem_rsp_i),
   .mem_err (mem_err_i),
   .tx_valid(tx_valid_o),
   .tx_ready(tx_ready_i),
   .tx_data (tx_data_o),
   .card_err(card_err_i),
   .st_bus  (status_o[2]),
   .st_cerr (status_o[5]),
   .st_asum (status_o[9]),
   .st_abort(status_o[10])
);

// File: tb/tb_desc_dma_engine.sv
`timescale 1ns/1ps
module tb_desc_dma_engine;
   localparam logic [31:0] OWN = 32'h8000_0000, NOINT = 32'h2, LAST = 32'h4,
                           FIRST = 32'h8, CHAIN = 32'h10, RING = 32'h20;

   logic clk = 0, rst_n = 0;
   logic csr_we = 0; logic [1:0] csr_sel = 0; logic [31:0] csr_wdata = 0;
   logic dir_rx = 0, card_err = 0;
   logic [31:0] status; logic irq, busy;
   logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
   logic mem_rsp = 0, mem_err = 0; logic [31:0] mem_rdata = 0;
   logic tx_valid; logic [31:0] tx_data; logic tx_ready = 0;
   logic rx_valid = 0; logic [31:0] rx_data; logic rx_ready;

   int checks = 0, errors = 0;
   int ready_mode = 2;
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   logic bk_we = 0; logic [13:0] bk_idx = 0; logic [31:0] bk_data = 0;
   logic [31:0] mem [0:16383];
   logic [31:0] tx_log [0:8191];
   int tx_n = 0, rx_cnt = 0, rd_total = 0;
   logic [31:0] rd_log [0:63];

   always #2 clk = ~clk;

   desc_dma_engine dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .dir_rx_i(dir_rx), .card_err_i(card_err),
      .status_o(status), .irq_o(irq), .busy_o(busy),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp), .mem_err_i(mem_err),
      .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
      .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .rx_ready_o(rx_ready));

   function automatic logic [31:0] patt(input int widx);
      return 32'hC0DE_0000 ^ (widx * 32'h9E37);
   endfunction

   function automatic int nwords(input int bytes);
      int b = (bytes > 8192) ? 8192 : bytes;
      return (b + 3) / 4;
   endfunction

   assign rx_data = 32'hA500_0000 + rx_cnt;

   // memory model: one-cycle response, reset fills a known pattern
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16384; i++) mem[i] <= patt(i);
         mem_rsp <= 0;
      end else begin
         mem_rsp <= 0;
         if (bk_we) mem[bk_idx] <= bk_data;
         if (mem_req && !mem_rsp) begin
            mem_rsp   <= 1;
            mem_err   <= (mem_addr == err_addr);
            mem_rdata <= mem[mem_addr[15:2]];
            if (mem_we && mem_addr != err_addr) mem[mem_addr[15:2]] <= mem_wdata;
            if (!mem_we) begin
               rd_log[rd_total % 64] <= mem_addr;
               rd_total <= rd_total + 1;
            end
         end
      end
      if (tx_valid && tx_ready) begin tx_log[tx_n] <= tx_data; tx_n <= tx_n + 1; end
      if (rx_valid && rx_ready) rx_cnt <= rx_cnt + 1;
   end

   always @(negedge clk) begin
      tx_ready = (ready_mode == 0) ? 1'b0 : (ready_mode == 1) ? 1'b1 : 1'($urandom % 2);
      rx_valid = 1'($urandom % 2);
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk); csr_we = 1; csr_sel = sel; csr_wdata = d;
      @(negedge clk); csr_we = 0;
   endtask

   task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); bk_we = 1; bk_idx = a[15:2]; bk_data = d;
      @(negedge clk); bk_we = 0;
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] b, input logic [31:0] n);
      wr_word(a, c); wr_word(a + 4, s); wr_word(a + 8, b); wr_word(a + 12, n);
   endtask

   task automatic soft_reset();
      csr(2'd0, 32'h1); @(negedge clk);
   endtask

   task automatic launch(input logic [31:0] base, input logic dir);
      dir_rx = dir; csr(2'd0, 32'h80); csr(2'd1, base);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 40000) begin @(negedge clk); n++; end
      if (busy) chk(0, "timeout waiting for idle", 32'd1, 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int t0, bad, exp_n, r0;
      logic [31:0] d [0:2]; logic [31:0] c [0:2]; logic [31:0] bf [0:2]; int sz [0:2];
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 R13 reset state
      chk(status == 0 && !irq && !busy && !mem_req, "R12 reset state", status, 32'h0);

      // R13: base write with run clear starts nothing
      r0 = rd_total;
      csr(2'd1, 32'h100); repeat (5) @(negedge clk);
      chk(!busy && rd_total == r0, "R13 no start while run clear", 32'(rd_total - r0), 32'h0);

      // R3 R5 R6 R7 R12: random chained transmit lists
      for (int it = 0; it < 3; it++) begin
         soft_reset();
         d[0] = 32'h100; d[1] = 32'h300; d[2] = 32'h180;
         c[0] = OWN | FIRST | NOINT | CHAIN; c[1] = OWN | NOINT | CHAIN; c[2] = OWN | LAST;
         for (int k = 0; k < 3; k++) begin
            sz[k] = $urandom % 41;
            bf[k] = 32'h1000 + k * 32'h400 + ($urandom % 16) * 4;
         end
         put_desc(d[0], c[0], sz[0], bf[0], d[1]);
         put_desc(d[1], c[1], sz[1], bf[1], d[2]);
         put_desc(d[2], c[2], sz[2], bf[2], 32'h0);
         csr(2'd3, 32'h1);
         ready_mode = 2; t0 = tx_n;
         launch(d[0], 0); wait_idle(); @(negedge clk);
         exp_n = nwords(sz[0]) + nwords(sz[1]) + nwords(sz[2]);
         chk(tx_n - t0 == exp_n, "R3 tx word count", 32'(tx_n - t0), 32'(exp_n));
         bad = 0; r0 = t0;
         for (int k = 0; k < 3; k++)
            for (int w = 0; w < nwords(sz[k]); w++) begin
               if (tx_log[r0] !== patt(int'(bf[k][15:2]) + w)) bad++;
               r0++;
            end
         chk(bad == 0, "R3 R6 tx data in chain order", 32'(bad), 32'h0);
         bad = 0;
         for (int k = 0; k < 3; k++) if (mem[d[k][15:2]] !== (c[k] & ~OWN)) bad++;
         chk(bad == 0, "R5 config write-back", 32'(bad), 32'h0);
         chk(status == 32'h101, "R7 done only after last", status, 32'h101);
         chk(irq == 1'b1, "R12 irq with tx enable", 32'(irq), 32'h1);
         csr(2'd2, 32'h1);
         chk(status == 32'h0 && !irq, "R12 write-one clear", status, 32'h0);
      end

      // R4 R6: receive, sequential descriptors
      soft_reset();
      put_desc(32'h400, OWN | FIRST | NOINT, 12, 32'h2000, 32'h0);
      put_desc(32'h410, OWN | LAST, 20, 32'h2100, 32'h0);
      r0 = rx_cnt;
      launch(32'h400, 1); wait_idle(); @(negedge clk);
      chk(rx_cnt - r0 == 8, "R4 rx word count", 32'(rx_cnt - r0), 32'h8);
      bad = 0;
      for (int w = 0; w < 3; w++) if (mem[(32'h2000 >> 2) + w] !== 32'hA500_0000 + r0 + w) bad++;
      for (int w = 0; w < 5; w++) if (mem[(32'h2100 >> 2) + w] !== 32'hA500_0000 + r0 + 3 + w) bad++;
      chk(bad == 0, "R4 R6 rx data placement", 32'(bad), 32'h0);
      chk(status == 32'h102, "R7 rx done", status, 32'h102);

      // R2: descriptor not owned
      soft_reset();
      put_desc(32'h500, FIRST | LAST, 16, 32'h2400, 32'h0);
      t0 = tx_n;
      launch(32'h500, 0); wait_idle(); @(negedge clk);
      chk(status == 32'h210, "R2 invalid status", status, 32'h210);
      chk(tx_n == t0 && !busy, "R2 no data moved", 32'(tx_n - t0), 32'h0);

      // R6: end of ring wraps to base, whose descriptor is now returned
      soft_reset();
      put_desc(32'h600, OWN | NOINT, 8, 32'h3800, 32'h0);
      put_desc(32'h610, OWN | RING, 4, 32'h3900, 32'h0);
      t0 = tx_n;
      launch(32'h600, 0); wait_idle(); @(negedge clk);
      chk(tx_n - t0 == 3, "R6 ring words", 32'(tx_n - t0), 32'h3);
      chk(status == 32'h311, "R6 ring wrap hits returned descriptor", status, 32'h311);

      // R8: bus error on second buffer read
      soft_reset();
      put_desc(32'h640, OWN | LAST, 16, 32'h3A00, 32'h0);
      err_addr = 32'h3A04; t0 = tx_n;
      launch(32'h640, 0); wait_idle(); @(negedge clk);
      chk(status == 32'h204, "R8 bus error status", status, 32'h204);
      chk(tx_n - t0 == 1, "R8 halt after error", 32'(tx_n - t0), 32'h1);
      chk(mem[32'h640 >> 2] == (OWN | LAST), "R8 no write-back", mem[32'h640 >> 2], OWN | LAST);
      err_addr = 32'hFFFF_FFFF;

      // R9: length clamp
      soft_reset();
      put_desc(32'h700, OWN | LAST, 9000, 32'h8000, 32'h0);
      ready_mode = 1; t0 = tx_n;
      launch(32'h700, 0); wait_idle(); @(negedge clk);
      chk(tx_n - t0 == nwords(9000), "R9 clamp word count", 32'(tx_n - t0), 32'(nwords(9000)));
      chk(tx_log[tx_n - 1] == patt((32'h8000 >> 2) + 2047), "R9 last clamped word",
          tx_log[tx_n - 1], patt((32'h8000 >> 2) + 2047));

      // R10: host abort
      soft_reset();
      put_desc(32'h780, OWN | LAST, 64, 32'h3000, 32'h0);
      ready_mode = 0;
      launch(32'h780, 0); repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R10 stalled before abort", 32'(busy), 32'h1);
      csr(2'd0, 32'h0); repeat (3) @(negedge clk);
      chk(!busy && status == 32'h600, "R10 abort status", status, 32'h600);

      // R11 R5: card error during a descriptor
      soft_reset();
      put_desc(32'h7C0, OWN | LAST, 8, 32'h3400, 32'h0);
      ready_mode = 0;
      launch(32'h7C0, 0); repeat (10) @(negedge clk);
      card_err = 1; @(negedge clk); card_err = 0;
      ready_mode = 2; wait_idle(); @(negedge clk);
      chk(status == 32'h321, "R11 card error status", status, 32'h321);
      chk(mem[32'h7C0 >> 2] == (LAST | 32'h4000_0000), "R5 card error write-back",
          mem[32'h7C0 >> 2], LAST | 32'h4000_0000);

      // R1 R3: zero-length descriptor and fetch order
      soft_reset();
      put_desc(32'h7E0, OWN | LAST, 0, 32'h3600, 32'h0);
      t0 = tx_n; r0 = rd_total;
      launch(32'h7E0, 0); wait_idle(); @(negedge clk);
      chk(tx_n == t0 && status == 32'h101, "R3 zero length", status, 32'h101);
      bad = 0;
      for (int k = 0; k < 4; k++) if (rd_log[(r0 + k) % 64] != 32'h7E0 + 4 * k) bad++;
      chk(bad == 0 && rd_total - r0 == 4, "R1 fetch order", 32'(rd_total - r0), 32'h4);
      chk(mem[32'h7E0 >> 2] == LAST, "R5 zero length write-back", mem[32'h7E0 >> 2], LAST);

      // R12: gating and soft reset
      chk(irq == 1'b0, "R12 irq masked", 32'(irq), 32'h0);
      soft_reset();
      chk(status == 32'h0, "R12 soft reset clears status", status, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule